// File: doc/BRIEF.md
# Nibble-Serial Byte ALU Sequencer

This block builds an 8-bit arithmetic or logic result from one 4-bit function core used twice. A controller first presents the low operand nibbles with the phase bit clear and strobes the store enable. It then presents the high operand nibbles with the phase bit set and strobes the store enable again. Each strobe writes the core output into the half of a byte-wide result register that the phase bit selects.

For addition, the carry from the low step is kept in an internal flip-flop. It becomes the core's carry input on the high step, so the two steps together behave as one 8-bit adder. Subtraction works through the same path: the controller inverts the second operand and sets the carry input.

The carry output is a register of its own. It is loaded only when the high nibble is stored, so it changes in the same cycle as the completed byte. AND, OR and XOR need no carry, and they give a carry of zero.

Top module: `nibble_alu_seq`

## Requirements
- R1: A synchronous reset clears the result register, the carry output and the internal low-step carry.
- R2: A store with the phase bit clear writes the core output into result bits 3..0 and leaves bits 7..4 unchanged.
- R3: A store with the phase bit set writes the core output into result bits 7..4 and leaves bits 3..0 unchanged.
- R4: When the store enable is low, the result and the carry output hold their values, whatever the operands and selects do. The result always shows the register contents, never the live core output.
- R5: On the low step with add selected, the core adds the operand nibbles plus the external carry input.
- R6: On the high step, the core carry input is the carry kept from the last low-step store, and the external carry input is ignored.
- R7: The carry output is loaded only by a store with the phase bit set. It then equals the carry out of the high-step addition.
- R8: AND, OR and XOR give the bitwise result of the operand nibbles and a carry of zero.
- R9: When no function select is active, a store writes zero into the selected nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opa | input | 4 | First operand nibble |
| opb | input | 4 | Second operand nibble |
| fn_add | input | 1 | Select addition |
| fn_and | input | 1 | Select bitwise AND |
| fn_xor | input | 1 | Select bitwise XOR |
| fn_or | input | 1 | Select bitwise OR |
| cin | input | 1 | Carry into the low step |
| phase_hi | input | 1 | 0: low nibble step, 1: high nibble step |
| res_we | input | 1 | Store the core output into the selected nibble |
| result | output | 8 | Registered byte result |
| cout | output | 1 | Registered carry of the high step |

## Verification
Every output is one register away from its inputs. A store strobed before a rising edge is visible in the result and the carry output after that edge. A complete byte operation is visible one edge after the high-step strobe.

The bench changes inputs on the falling edge and samples on the next falling edge. After the low step it checks the low nibble, the held high nibble and the unchanged carry. After the high step it checks the full byte and the carry. During the high step it drives the external carry to the opposite of its low-step value, so any leak of that input into the high step shows up in the result.

// File: rtl/nibble_alu_seq.sv
module nibble_alu_seq #(
  parameter int NIB = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NIB-1:0] opa,
  input  logic [NIB-1:0] opb,
  input  logic           fn_add,
  input  logic           fn_and,
  input  logic           fn_xor,
  input  logic           fn_or,
  input  logic           cin,
  input  logic           phase_hi,
  input  logic           res_we,
  output logic [2*NIB-1:0] result,
  output logic           cout
);
  localparam int W = 2 * NIB;

  logic [W-1:0]   res_q;
  logic           lo_carry_q;
  logic           cout_q;
  logic           core_cin;
  logic [NIB:0]   sum_x;
  logic [NIB-1:0] core_y;
  logic           core_c;

  assign core_cin = phase_hi ? lo_carry_q : cin;
  assign sum_x    = {1'b0, opa} + {1'b0, opb} + {{NIB{1'b0}}, core_cin};
  assign core_y   = ({NIB{fn_add}} & sum_x[NIB-1:0])
                  | ({NIB{fn_and}} & (opa & opb))
                  | ({NIB{fn_xor}} & (opa ^ opb))
                  | ({NIB{fn_or}}  & (opa | opb));
  assign core_c   = fn_add & sum_x[NIB];

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q      <= '0;
      lo_carry_q <= 1'b0;
      cout_q     <= 1'b0;
    end else if (res_we) begin
      if (phase_hi) begin
        res_q[W-1:NIB] <= core_y;
        cout_q         <= core_c;
      end else begin
        res_q[NIB-1:0] <= core_y;
        lo_carry_q     <= core_c;
      end
    end
  end

  assign result = res_q;
  assign cout   = cout_q;
endmodule

module nibble_alu_seq_chk #(
  parameter int NIB = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           fn_add,
  input logic           phase_hi,
  input logic           res_we,
  input logic [2*NIB-1:0] result,
  input logic           cout
);
  localparam int W = 2 * NIB;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (result == '0 && !cout));

  // R2
  hi_hold_on_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (res_we && !phase_hi) |=> $stable(result[W-1:NIB]));

  // R3
  lo_hold_on_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (res_we && phase_hi) |=> $stable(result[NIB-1:0]));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !res_we |=> ($stable(result) && $stable(cout)));

  // R7
  cout_only_hi_chk: assert property (@(posedge clk) disable iff (rst)
    !(res_we && phase_hi) |=> $stable(cout));

  // R8
  logic_no_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (res_we && phase_hi && !fn_add) |=> !cout);
endmodule

bind nibble_alu_seq nibble_alu_seq_chk #(.NIB(NIB)) u_chk (
  .clk(clk), .rst(rst), .fn_add(fn_add), .phase_hi(phase_hi),
  .res_we(res_we), .result(result), .cout(cout)
);

// File: tb/test_nibble_alu_seq.sv
module test_nibble_alu_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] opa = '0, opb = '0;
  logic       fn_add = 0, fn_and = 0, fn_xor = 0, fn_or = 0;
  logic       cin = 0, phase_hi = 0, res_we = 0;
  logic [7:0] result;
  logic       cout;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  nibble_alu_seq i_nibble_alu_seq (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb),
    .fn_add(fn_add), .fn_and(fn_and), .fn_xor(fn_xor), .fn_or(fn_or),
    .cin(cin), .phase_hi(phase_hi), .res_we(res_we),
    .result(result), .cout(cout)
  );

  // a, b, op (0 add, 1 and, 2 xor, 3 or), cin, expected result, expected carry
  localparam logic [27:0] VEC [9] = '{
    {8'h3A, 8'h47, 2'd0, 1'b0, 8'h81, 1'b0},
    {8'hFF, 8'h01, 2'd0, 1'b0, 8'h00, 1'b1},
    {8'h0F, 8'h00, 2'd0, 1'b1, 8'h10, 1'b0},
    {8'h80, 8'h80, 2'd0, 1'b1, 8'h01, 1'b1},
    {8'h50, 8'hDF, 2'd0, 1'b1, 8'h30, 1'b1},
    {8'hC3, 8'h5A, 2'd1, 1'b0, 8'h42, 1'b0},
    {8'hC3, 8'h5A, 2'd2, 1'b1, 8'h99, 1'b0},
    {8'hC3, 8'h5A, 2'd3, 1'b1, 8'hDB, 1'b0},
    {8'h08, 8'h08, 2'd0, 1'b0, 8'h10, 1'b0}
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_op(input logic [1:0] op);
    fn_add = (op == 2'd0); fn_and = (op == 2'd1);
    fn_xor = (op == 2'd2); fn_or  = (op == 2'd3);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] prev_res;
    logic       prev_c;
    @(negedge clk); @(negedge clk);
    // R1: reset state
    check("R1", {cout, result}, 9'h000);
    rst = 0;
    prev_res = 8'h00; prev_c = 1'b0;

    foreach (VEC[i]) begin
      logic [7:0] a, b, er;
      logic [1:0] op;
      logic c, ec;
      a = VEC[i][27:20]; b = VEC[i][19:12]; op = VEC[i][11:10];
      c = VEC[i][9]; er = VEC[i][8:1]; ec = VEC[i][0];
      set_op(op);
      opa = a[3:0]; opb = b[3:0]; cin = c; phase_hi = 0; res_we = 1;
      @(negedge clk);
      // R2/R5: low nibble written, high held; R7: carry unchanged
      check("R2/R5 low step", {cout, result}, {prev_c, prev_res[7:4], er[3:0]});
      // R6: flip external carry on the high step, it must be ignored
      opa = a[7:4]; opb = b[7:4]; cin = ~c; phase_hi = 1;
      @(negedge clk);
      // R3/R6/R7/R8: full byte and carry
      check("R3/R6/R7/R8 byte", {cout, result}, {ec, er});
      res_we = 0; opa = ~opa; opb = 4'h5; phase_hi = 0; set_op(2'd3);
      @(negedge clk);
      // R4: no store, result and carry hold
      check("R4 hold", {cout, result}, {ec, er});
      prev_res = er; prev_c = ec;
    end

    // R9: no select active writes zero into the chosen nibble
    fn_add = 0; fn_and = 0; fn_xor = 0; fn_or = 0;
    opa = 4'hF; opb = 4'hF; phase_hi = 1; res_we = 1;
    @(negedge clk);
    check("R9 no select", {cout, result}, {1'b0, 4'h0, prev_res[3:0]});

    // R1: reset clears everything, including the kept low carry
    set_op(2'd0); opa = 4'hF; opb = 4'h1; phase_hi = 0; res_we = 1; cin = 0;
    @(negedge clk);
    rst = 1; res_we = 0;
    @(negedge clk);
    check("R1 reset", {cout, result}, 9'h000);
    rst = 0;
    // high step straight after reset: kept carry must be 0, cin ignored (R1, R6)
    opa = 4'hF; opb = 4'h0; cin = 1; phase_hi = 1; res_we = 1;
    @(negedge clk);
    check("R1/R6 carry cleared", {cout, result}, {1'b0, 8'hF0});
    res_we = 0;
    @(negedge clk);
    check("R4 idle", {cout, result}, {1'b0, 8'hF0});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule